// File: doc/BRIEF.md
# PWM Global Channel Control Bank

This block is the shared control bank that sits in front of a group of PWM channel counters. It keeps one enable bit per implemented channel and drives these bits to the counters. It latches the period-end pulse that each channel emits into a sticky event flag. It filters those flags through an interrupt mask and combines the result into one interrupt line. Software reaches the bank through a small word-addressed register port. The enable bits and the mask bits are never written directly. Each has a pair of strobe registers, one that sets the bits written as 1 and one that clears them, so two software agents can change different channels without a read-modify-write race. Reading the event flag register returns the pending flags and acknowledges them in the same access.

The register port also decodes the per-channel address windows above the global bank. It raises one select line per implemented channel, and the channel block behind that line owns the content of its window. One 32-bit mode word is held for the channel clocking logic and is driven out unchanged. Global registers occupy byte offsets 0x00 to 0x1C, one 32-bit word each. The bank is built for up to 32 channels, and the parameter `NUM_CH` sets how many exist.

Top module: `pwm_ctl_bank`

## Requirements
- R1: A synchronous active-low reset clears the enable bits, mask bits, event flags and mode word, drives `irq` low and returns zero on `bus_rdata`.
- R2: A write to offset 0x04 sets enable bit n for every 1 in bit n of the written data and leaves the other bits unchanged. Offset 0x0C reads the enable bits, and they also appear on `chan_enable`.
- R3: A write to offset 0x08 clears enable bit n for every 1 in bit n of the written data and leaves the other bits unchanged.
- R4: Writes to offsets 0x10 and 0x14 set and clear mask bits in the same way. Offset 0x18 reads the mask.
- R5: A high on `period_end[n]` in any cycle sets event flag n, which stays set until it is acknowledged. Offset 0x1C reads the flags.
- R6: A read of offset 0x1C clears every flag it returns. A period-end pulse that arrives in the same cycle as that read remains pending afterwards.
- R7: `irq` is high exactly when some event flag and its mask bit are both set. It follows the register state with no further delay.
- R8: Bits at positions `NUM_CH` and above read as zero in the enable, mask and flag registers, and writes to them have no effect.
- R9: Offset 0x00 is a 32-bit read/write mode word, driven on `mode_cfg`.
- R10: While `bus_sel` is high and the byte address lies in [0x200 + 0x20·n, 0x200 + 0x20·(n+1)) for an implemented channel n, `chan_sel[n]` is high. Otherwise no select is high, and at most one is high at any time.
- R11: Read data appears on `bus_rdata` in the cycle after a read strobe and is zero in every other cycle. The write-only offsets 0x04, 0x08, 0x10 and 0x14, misaligned addresses and all addresses outside the global bank read zero. Writes to the read-only offsets 0x0C, 0x18 and 0x1C have no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| bus_sel | input | 1 | Register port access valid |
| bus_wr | input | 1 | Write strobe |
| bus_rd | input | 1 | Read strobe |
| bus_addr | input | ADDR_W | Byte address |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, one cycle after the read strobe |
| period_end | input | NUM_CH | Per-channel end-of-period pulse |
| chan_enable | output | NUM_CH | Per-channel counter enable |
| chan_sel | output | NUM_CH | Per-channel register window select |
| mode_cfg | output | 32 | Mode word for the channel clocking logic |
| irq | output | 1 | Interrupt request |

## Verification
The bench builds the bank with its defaults: four channels inside a 32-bit register word and a 12-bit address. With these values, bit positions 4 to 31 are real unimplemented lanes, so R8 can be tested by writing all-ones patterns into them. The channel windows for channels 4 to 31 also fall inside the address space, which lets the bench show that their selects stay low. The 12-bit address leaves room to probe the first and last byte of each implemented window.

// File: rtl/pwm_ctl_pkg.sv
// Shared definitions for the PWM global control bank.
// Assumes a 32-bit register word and word-aligned global registers.
package pwm_ctl_pkg;

    localparam int DATA_W       = 32;
    localparam int WIN_BASE     = 'h200;  // first per-channel window
    localparam int WIN_STRIDE   = 'h20;   // bytes per channel window
    localparam int GLB_SPAN_LG  = 5;      // global bank spans 32 bytes

    // Word index of each global register (bus_addr[4:2]).
    typedef enum logic [2:0] {
        REG_MODE  = 3'd0,
        REG_ENSET = 3'd1,
        REG_ENCLR = 3'd2,
        REG_ENSTS = 3'd3,
        REG_MKSET = 3'd4,
        REG_MKCLR = 3'd5,
        REG_MKSTS = 3'd6,
        REG_EVFLG = 3'd7
    } greg_e;

endpackage

// File: rtl/pwm_ctl_decode.sv
// Address decoder for the PWM control bank.
// Flags accesses to the global bank, names the global register addressed,
// and raises a one-hot select for each implemented channel window.
// Assumes ADDR_W is wide enough to hold every channel window.
module pwm_ctl_decode
    import pwm_ctl_pkg::*;
#(
    parameter int NUM_CH = 4,
    parameter int ADDR_W = 12
) (
    input  logic              bus_sel,
    input  logic [ADDR_W-1:0] bus_addr,
    output logic              glb_hit,
    output greg_e             glb_reg,
    output logic [NUM_CH-1:0] chan_sel
);

    localparam int HI_W = ADDR_W - GLB_SPAN_LG;

    // Global bank hit: word-aligned address inside the first 32 bytes.
    always_comb begin
        glb_hit = bus_sel
               && (bus_addr[ADDR_W-1:GLB_SPAN_LG] == HI_W'(0))
               && (bus_addr[1:0] == 2'b00);
        glb_reg = greg_e'(bus_addr[4:2]);
    end

    // One address-range comparator per implemented channel window.
    for (genvar n = 0; n < NUM_CH; n++) begin : g_win
        localparam logic [ADDR_W-1:0] LO = ADDR_W'(WIN_BASE + n * WIN_STRIDE);
        localparam logic [ADDR_W-1:0] HI = ADDR_W'(WIN_BASE + (n + 1) * WIN_STRIDE);
        assign chan_sel[n] = bus_sel && (bus_addr >= LO) && (bus_addr < HI);
    end

endmodule

// File: rtl/pwm_ctl_setclr.sv
// Bit vector changed only through write-one-to-set and write-one-to-clear
// strobes. Zero bits in the data leave the stored bits unchanged.
// Assumes set and clear never come in the same cycle (distinct offsets).
module pwm_ctl_setclr #(
    parameter int W = 4
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         set_stb,
    input  logic         clr_stb,
    input  logic [W-1:0] wbits,
    output logic [W-1:0] q
);

    logic [W-1:0] q_nxt;

    // Next value: OR in set bits, mask out clear bits.
    always_comb begin
        q_nxt = q;
        if (set_stb) q_nxt = q_nxt | wbits;
        if (clr_stb) q_nxt = q_nxt & ~wbits;
    end

    // Storage with synchronous reset.
    always_ff @(posedge clk) begin
        if (!rst_n) q <= '0;
        else        q <= q_nxt;
    end

endmodule

// File: rtl/pwm_ctl_evt.sv
// Sticky event flags with acknowledge-on-read.
// A flag is set by its event pulse and cleared when the flag register is
// read. An event in the same cycle as the read wins over the clear.
module pwm_ctl_evt #(
    parameter int W = 4
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] evt,
    input  logic         ack,
    output logic [W-1:0] flags
);

    // Latch events; an acknowledging read drops every flag it returned.
    always_ff @(posedge clk) begin
        if (!rst_n) flags <= '0;
        else        flags <= (ack ? '0 : flags) | evt;
    end

endmodule

// File: rtl/pwm_ctl_bank.sv
// Global control bank for a group of PWM channels.
// Holds the channel enables, the interrupt mask and the period-end flags,
// holds a mode word for the clocking logic, and decodes the channel windows.
// Read data is registered. Assumes 1 <= NUM_CH <= 32.
module pwm_ctl_bank
    import pwm_ctl_pkg::*;
#(
    parameter int NUM_CH = 4,
    parameter int ADDR_W = 12
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              bus_sel,
    input  logic              bus_wr,
    input  logic              bus_rd,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [31:0]       bus_wdata,
    output logic [31:0]       bus_rdata,
    input  logic [NUM_CH-1:0] period_end,
    output logic [NUM_CH-1:0] chan_enable,
    output logic [NUM_CH-1:0] chan_sel,
    output logic [31:0]       mode_cfg,
    output logic              irq
);

    logic              glb_hit;
    greg_e             glb_reg;
    logic              wr_go;
    logic              rd_go;
    logic [NUM_CH-1:0] mask_q;
    logic [NUM_CH-1:0] isr_q;
    logic [31:0]       rd_val;

    pwm_ctl_decode #(.NUM_CH(NUM_CH), .ADDR_W(ADDR_W)) i_dec (
        .bus_sel  (bus_sel),
        .bus_addr (bus_addr),
        .glb_hit  (glb_hit),
        .glb_reg  (glb_reg),
        .chan_sel (chan_sel)
    );

    // Qualified write and read strobes for the global bank.
    always_comb begin
        wr_go = glb_hit && bus_wr;
        rd_go = glb_hit && bus_rd;
    end

    pwm_ctl_setclr #(.W(NUM_CH)) i_enable (
        .clk     (clk),
        .rst_n   (rst_n),
        .set_stb (wr_go && (glb_reg == REG_ENSET)),
        .clr_stb (wr_go && (glb_reg == REG_ENCLR)),
        .wbits   (bus_wdata[NUM_CH-1:0]),
        .q       (chan_enable)
    );

    pwm_ctl_setclr #(.W(NUM_CH)) i_mask (
        .clk     (clk),
        .rst_n   (rst_n),
        .set_stb (wr_go && (glb_reg == REG_MKSET)),
        .clr_stb (wr_go && (glb_reg == REG_MKCLR)),
        .wbits   (bus_wdata[NUM_CH-1:0]),
        .q       (mask_q)
    );

    pwm_ctl_evt #(.W(NUM_CH)) i_evt (
        .clk   (clk),
        .rst_n (rst_n),
        .evt   (period_end),
        .ack   (rd_go && (glb_reg == REG_EVFLG)),
        .flags (isr_q)
    );

    // Mode word: plain read/write register.
    always_ff @(posedge clk) begin
        if (!rst_n)                           mode_cfg <= '0;
        else if (wr_go && glb_reg == REG_MODE) mode_cfg <= bus_wdata;
    end

    // Read multiplexer; write-only offsets return zero.
    always_comb begin
        case (glb_reg)
            REG_MODE:  rd_val = mode_cfg;
            REG_ENSTS: rd_val = DATA_W'(chan_enable);
            REG_MKSTS: rd_val = DATA_W'(mask_q);
            REG_EVFLG: rd_val = DATA_W'(isr_q);
            default:   rd_val = '0;
        endcase
    end

    // Registered read data, zero outside read responses.
    always_ff @(posedge clk) begin
        if (!rst_n) bus_rdata <= '0;
        else        bus_rdata <= rd_go ? rd_val : '0;
    end

    // Interrupt: any pending flag that is unmasked.
    assign irq = |(isr_q & mask_q);

endmodule

// File: rtl/pwm_ctl_bank_chk.sv
// Assertion checker for pwm_ctl_bank, attached with bind below.
// Observes the register port, the channel signals and the event flags.
module pwm_ctl_bank_chk #(
    parameter int NUM_CH = 4,
    parameter int ADDR_W = 12
) (
    input logic              clk,
    input logic              rst_n,
    input logic              bus_sel,
    input logic              bus_wr,
    input logic              bus_rd,
    input logic [ADDR_W-1:0] bus_addr,
    input logic [31:0]       bus_wdata,
    input logic [31:0]       bus_rdata,
    input logic [NUM_CH-1:0] period_end,
    input logic [NUM_CH-1:0] chan_enable,
    input logic [NUM_CH-1:0] chan_sel,
    input logic [NUM_CH-1:0] isr_q,
    input logic              irq
);

    localparam logic [31:0] IMPL = (NUM_CH >= 32) ? '1 : ((32'd1 << NUM_CH) - 32'd1);
    localparam logic [ADDR_W-1:0] A_ENSET = ADDR_W'(4);
    localparam logic [ADDR_W-1:0] A_ENCLR = ADDR_W'(8);
    localparam logic [ADDR_W-1:0] A_EVFLG = ADDR_W'(28);

    assert_enable_set_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_sel && bus_wr && bus_addr == A_ENSET)
        |=> ((chan_enable & $past(bus_wdata[NUM_CH-1:0])) == $past(bus_wdata[NUM_CH-1:0])));

    assert_enable_clear_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_sel && bus_wr && bus_addr == A_ENCLR)
        |=> ((chan_enable & $past(bus_wdata[NUM_CH-1:0])) == '0));

    assert_event_latch_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (period_end != '0) |=> ((isr_q & $past(period_end)) == $past(period_end)));

    assert_read_ack_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_sel && bus_rd && bus_addr == A_EVFLG && period_end == '0) |=> (isr_q == '0));

    assert_irq_idle_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (isr_q == '0) |-> !irq);

    assert_unimpl_zero_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_sel && bus_rd && bus_addr[ADDR_W-1:2] != '0) |=> ((bus_rdata & ~IMPL) == '0));

    assert_sel_onehot_R10: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(chan_sel));

    assert_sel_idle_R10: assert property (@(posedge clk) disable iff (!rst_n)
        !bus_sel |-> (chan_sel == '0));

    assert_rdata_quiet_R11: assert property (@(posedge clk) disable iff (!rst_n)
        !bus_rd |=> (bus_rdata == '0));

endmodule

bind pwm_ctl_bank pwm_ctl_bank_chk #(.NUM_CH(NUM_CH), .ADDR_W(ADDR_W)) i_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .bus_sel     (bus_sel),
    .bus_wr      (bus_wr),
    .bus_rd      (bus_rd),
    .bus_addr    (bus_addr),
    .bus_wdata   (bus_wdata),
    .bus_rdata   (bus_rdata),
    .period_end  (period_end),
    .chan_enable (chan_enable),
    .chan_sel    (chan_sel),
    .isr_q       (isr_q),
    .irq         (irq)
);

// File: tb/test_pwm_ctl_bank.sv
`timescale 1ns/1ps
// Self-checking bench for pwm_ctl_bank: vector table, then directed tests.
module test_pwm_ctl_bank;

    localparam int NUM_CH = 4;
    localparam int ADDR_W = 12;

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic              bus_sel = 1'b0;
    logic              bus_wr = 1'b0;
    logic              bus_rd = 1'b0;
    logic [ADDR_W-1:0] bus_addr = '0;
    logic [31:0]       bus_wdata = '0;
    logic [31:0]       bus_rdata;
    logic [NUM_CH-1:0] period_end = '0;
    logic [NUM_CH-1:0] chan_enable;
    logic [NUM_CH-1:0] chan_sel;
    logic [31:0]       mode_cfg;
    logic              irq;

    int checks = 0;
    int errors = 0;

    always #4 clk = ~clk;  // 125 MHz

    pwm_ctl_bank #(.NUM_CH(NUM_CH), .ADDR_W(ADDR_W)) i_pwm_ctl_bank (
        .clk, .rst_n, .bus_sel, .bus_wr, .bus_rd, .bus_addr, .bus_wdata,
        .bus_rdata, .period_end, .chan_enable, .chan_sel, .mode_cfg, .irq
    );

    // op: 0 write, 1 read and compare, 2 period-end pulse, 3 compare irq
    typedef struct packed {
        logic [1:0]  op;
        logic [11:0] addr;
        logic [31:0] data;
        logic [7:0]  req;
    } vec_t;

    localparam int NV = 28;
    localparam vec_t VEC [NV] = '{
        '{2'd0, 12'h004, 32'h5,        8'd2},  // R2 set 0 and 2
        '{2'd1, 12'h00C, 32'h5,        8'd2},
        '{2'd0, 12'h004, 32'h2,        8'd2},  // R2 zero bits keep state
        '{2'd1, 12'h00C, 32'h7,        8'd2},
        '{2'd0, 12'h008, 32'h4,        8'd3},  // R3 clear bit 2
        '{2'd1, 12'h00C, 32'h3,        8'd3},
        '{2'd0, 12'h004, 32'hFFFFFFF0, 8'd8},  // R8 upper lanes ignored
        '{2'd1, 12'h00C, 32'h3,        8'd8},
        '{2'd0, 12'h010, 32'h9,        8'd4},  // R4 mask set
        '{2'd1, 12'h018, 32'h9,        8'd4},
        '{2'd0, 12'h014, 32'h8,        8'd4},  // R4 mask clear
        '{2'd1, 12'h018, 32'h1,        8'd4},
        '{2'd0, 12'h010, 32'hF0,       8'd8},  // R8 mask upper lanes
        '{2'd1, 12'h018, 32'h1,        8'd8},
        '{2'd2, 12'h000, 32'h6,        8'd5},  // R5 events on 1 and 2
        '{2'd3, 12'h000, 32'h0,        8'd7},  // R7 masked out
        '{2'd1, 12'h01C, 32'h6,        8'd5},  // R5 flags read
        '{2'd1, 12'h01C, 32'h0,        8'd6},  // R6 read cleared them
        '{2'd2, 12'h000, 32'h1,        8'd5},
        '{2'd3, 12'h000, 32'h1,        8'd7},  // R7 unmasked flag
        '{2'd1, 12'h01C, 32'h1,        8'd6},
        '{2'd3, 12'h000, 32'h0,        8'd7},  // R7 drops after ack
        '{2'd0, 12'h000, 32'hA5A51234, 8'd9},  // R9 mode word
        '{2'd1, 12'h000, 32'hA5A51234, 8'd9},
        '{2'd1, 12'h004, 32'h0,        8'd11}, // R11 write-only reads 0
        '{2'd0, 12'h00C, 32'hF,        8'd11}, // R11 read-only ignores write
        '{2'd1, 12'h00C, 32'h3,        8'd11},
        '{2'd1, 12'h240, 32'h0,        8'd11}  // R11 window reads 0
    };

    task automatic check(input string req, input logic [31:0] got, input logic [31:0] exp);
        checks++;
        if (got !== exp) begin
            errors++;
            $display("FAIL %s: got %h expected %h", req, got, exp);
        end
    endtask

    task automatic bus_write(input logic [11:0] a, input logic [31:0] d);
        @(negedge clk);
        bus_sel = 1'b1; bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
        @(negedge clk);
        bus_sel = 1'b0; bus_wr = 1'b0;
    endtask

    task automatic bus_read(input logic [11:0] a, input logic [NUM_CH-1:0] pe, output logic [31:0] v);
        @(negedge clk);
        bus_sel = 1'b1; bus_rd = 1'b1; bus_addr = a; period_end = pe;
        @(negedge clk);
        bus_sel = 1'b0; bus_rd = 1'b0; period_end = '0;
        v = bus_rdata;
    endtask

    task automatic pulse(input logic [NUM_CH-1:0] pe);
        @(negedge clk);
        period_end = pe;
        @(negedge clk);
        period_end = '0;
    endtask

    task automatic finish_run();
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    endtask

    initial begin
        #(8 * 200000);
        checks++;
        errors++;
        $display("FAIL watchdog: got timeout expected completion");
        finish_run();
    end

    initial begin
        logic [31:0] v;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;

        // R1 reset state
        check("R1 enable", 32'(chan_enable), 32'h0);
        check("R1 irq", 32'(irq), 32'h0);
        check("R1 mode", mode_cfg, 32'h0);
        check("R1 rdata", bus_rdata, 32'h0);
        bus_read(12'h018, '0, v); check("R1 mask", v, 32'h0);
        bus_read(12'h01C, '0, v); check("R1 flags", v, 32'h0);

        // Vector table
        for (int i = 0; i < NV; i++) begin
            case (VEC[i].op)
                2'd0: bus_write(VEC[i].addr, VEC[i].data);
                2'd1: begin
                    bus_read(VEC[i].addr, '0, v);
                    check($sformatf("R%0d vec %0d", VEC[i].req, i), v, VEC[i].data);
                end
                2'd2: pulse(VEC[i].data[NUM_CH-1:0]);
                default: check($sformatf("R%0d vec %0d irq", VEC[i].req, i), 32'(irq), VEC[i].data);
            endcase
        end

        // R2 and R9 on the output ports
        check("R2 chan_enable", 32'(chan_enable), 32'h3);
        check("R9 mode_cfg", mode_cfg, 32'hA5A51234);

        // R6 event in the same cycle as the acknowledging read
        pulse(4'h1);
        bus_read(12'h01C, 4'h2, v); check("R6 returned", v, 32'h1);
        bus_read(12'h01C, '0, v);   check("R6 kept", v, 32'h2);

        // R11 misaligned global access reads zero
        bus_read(12'h00D, '0, v); check("R11 misaligned", v, 32'h0);

        // R10 window selects
        @(negedge clk);
        bus_sel = 1'b1; bus_addr = 12'h240; #1;
        check("R10 ch2", 32'(chan_sel), 32'h4);
        bus_addr = 12'h200; #1;
        check("R10 ch0 first", 32'(chan_sel), 32'h1);
        bus_addr = 12'h27F; #1;
        check("R10 ch3 last", 32'(chan_sel), 32'h8);
        bus_addr = 12'h280; #1;
        check("R10 ch4 absent", 32'(chan_sel), 32'h0);
        bus_addr = 12'h1FC; #1;
        check("R10 below window", 32'(chan_sel), 32'h0);
        bus_sel = 1'b0; bus_addr = 12'h240; #1;
        check("R10 no select", 32'(chan_sel), 32'h0);

        // R1 reset in mid-run with state and irq active
        pulse(4'h1);
        check("R7 irq before reset", 32'(irq), 32'h1);
        @(negedge clk); rst_n = 1'b0;
        @(negedge clk); rst_n = 1'b1;
        check("R1 enable after reset", 32'(chan_enable), 32'h0);
        check("R1 irq after reset", 32'(irq), 32'h0);
        check("R1 mode after reset", mode_cfg, 32'h0);
        bus_read(12'h01C, '0, v); check("R1 flags after reset", v, 32'h0);
        bus_read(12'h018, '0, v); check("R1 mask after reset", v, 32'h0);

        finish_run();
    end

endmodule